// File: doc/BRIEF.md
# Switch-Tail Timing Generator

This block is a twisted-ring counter with `STAGES` flip-flops (default 4). The first stage takes the complement of the last stage, and every other stage copies the stage before it. From the all-zeros reset state this gives a loop of `2*STAGES` states. A bank of `2*STAGES` two-input AND gates turns the current state into a one-hot phase vector. System logic uses these phases as a repeating train of non-overlapping timing slots.

A plain twisted ring never leaves an unused pattern once it is in one. Here the next-state input of stage 2 is `(stage0 | stage2) & stage1` instead of a plain copy of stage 1. With this change, every unused pattern of the default 4-stage ring returns to the legal loop within a few enabled clocks, and the legal loop itself is left unchanged. A synchronous seed port can force any pattern into the register, which is how the recovery behaviour is exercised.

Top module: `johnson_timing_gen`

## Requirements
- R1: While `rst_n` is low, `state_q` is all zeros and `phase_oh` is 1 (bit 0 alone set).
- R2: With `enable` high and `seed_load` low, a legal state `state_q` steps through the loop 0000, 0001, 0011, 0111, 1111, 1110, 1100, 1000 and back to 0000 (written as `state_q[3:0]`, default width). In general, state number n (0 ≤ n < 2·STAGES) has bits [n-1:0] set for n ≤ STAGES, and bits [STAGES-1:n-STAGES] set otherwise.
- R3: On each enabled step, `state_q[0]` takes the inverse of the previous `state_q[STAGES-1]`, and `state_q[1]` takes the previous `state_q[0]`.
- R4: In legal state number n, `phase_oh` has exactly bit n set.
- R5: For any register pattern, each phase bit is the AND of two stage literals. For j = 0 it is ~s[0]&~s[K-1] and for j = K it is s[0]&s[K-1]. For 1 ≤ j < K, bit j is s[j-1]&~s[j] and bit K+j is ~s[j-1]&s[j].
- R6: With `enable` and `seed_load` both low, `state_q` and `phase_oh` keep their values across a clock edge.
- R7: When `seed_load` is high at a clock edge, `state_q` takes `seed_value` regardless of `enable`.
- R8: From any of the 2^STAGES patterns, an enabled register reaches a legal state within 2·STAGES clocks and then follows R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low, clears all stages |
| enable | input | 1 | Advance the ring by one step on this edge |
| seed_load | input | 1 | Force `seed_value` into the stages on this edge |
| seed_value | input | STAGES | Pattern written by `seed_load` |
| state_q | output | STAGES | Raw stage contents, bit 0 is the first stage |
| phase_oh | output | 2*STAGES | Decoded timing phases |

## Verification
A long free run from reset compares every state and phase against a loop position that the bench computes. This separates a wrong feedback polarity or shift direction from a wrong decode pair. All sixteen 4-bit patterns are then seeded with the ring stalled, so the two-literal decode is checked on illegal patterns as well as legal ones. Each pattern is then released and the clocks to recovery are counted, which exposes a missing or altered correction term. Enable-low stalls and a seed issued together with enable show the hold and priority rules apart from the stepping logic.

// File: rtl/jc_pkg.sv
package jc_pkg;

  // A legal twisted-ring state is a single run of ones: at most one
  // place where neighbouring stages differ (ring seam not counted).
  function automatic logic jc_is_monotone(input logic [31:0] s, input int unsigned k);
    int unsigned edges;
    edges = 0;
    for (int unsigned i = 0; i + 1 < k; i++) begin
      if (s[i] != s[i+1]) edges++;
    end
    return (edges <= 1);
  endfunction

  // Next-state value of the corrected stage.
  function automatic logic jc_fix_bit(input logic head, input logic prev, input logic self);
    return (head | self) & prev;
  endfunction

endpackage

// File: rtl/jc_shift_core.sv
module jc_shift_core #(
  parameter int STAGES  = 4,
  parameter int FIX_IDX = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              seed_load,
  input  logic [STAGES-1:0] seed_value,
  output logic [STAGES-1:0] stage_q,
  output logic              advance
);
  import jc_pkg::*;

  logic [STAGES-1:0] stepped;
  logic [STAGES-1:0] stage_d;

  assign advance = enable & ~seed_load;

  // Feedback of the tail stage and straight shift, stage FIX_IDX corrected.
  assign stepped[0] = ~stage_q[STAGES-1];
  for (genvar i = 1; i < STAGES; i++) begin : g_shift
    if (i == FIX_IDX) begin : g_fix
      assign stepped[i] = jc_fix_bit(stage_q[0], stage_q[i-1], stage_q[i]);
    end else begin : g_plain
      assign stepped[i] = stage_q[i-1];
    end
  end

  always_comb begin
    if (seed_load)    stage_d = seed_value;
    else if (advance) stage_d = stepped;
    else              stage_d = stage_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end
endmodule

// File: rtl/jc_phase_decode.sv
module jc_phase_decode #(
  parameter int STAGES = 4,
  localparam int PHASES = 2 * STAGES
) (
  input  logic [STAGES-1:0] stage_q,
  output logic [PHASES-1:0] phase
);
  // One two-input gate per phase: edges of the run of ones.
  for (genvar j = 0; j < STAGES; j++) begin : g_gate
    if (j == 0) begin : g_ends
      assign phase[0]      = ~stage_q[0] & ~stage_q[STAGES-1];
      assign phase[STAGES] =  stage_q[0] &  stage_q[STAGES-1];
    end else begin : g_mid
      assign phase[j]          =  stage_q[j-1] & ~stage_q[j];
      assign phase[STAGES + j] = ~stage_q[j-1] &  stage_q[j];
    end
  end
endmodule

// File: rtl/johnson_timing_gen.sv
module johnson_timing_gen #(
  parameter int STAGES = 4,
  localparam int PHASES = 2 * STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              seed_load,
  input  logic [STAGES-1:0] seed_value,
  output logic [STAGES-1:0] state_q,
  output logic [PHASES-1:0] phase_oh
);
  import jc_pkg::*;

  logic advance_w;
  logic legal_w;

  jc_shift_core #(.STAGES(STAGES), .FIX_IDX(2)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .seed_load  (seed_load),
    .seed_value (seed_value),
    .stage_q    (state_q),
    .advance    (advance_w)
  );

  jc_phase_decode #(.STAGES(STAGES)) u_dec (
    .stage_q (state_q),
    .phase   (phase_oh)
  );

  // Named event for the checker: the register holds a legal loop state.
  assign legal_w = jc_is_monotone(32'(state_q), STAGES);
endmodule

// File: rtl/jc_timing_checker.sv
module jc_timing_checker #(
  parameter int STAGES = 4,
  localparam int PHASES = 2 * STAGES,
  localparam int LIMIT  = 2 * STAGES
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              seed_load,
  input logic [STAGES-1:0] seed_value,
  input logic [STAGES-1:0] state_q,
  input logic [PHASES-1:0] phase_oh,
  input logic              legal,
  input logic              advance
);
  logic [7:0] bad_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   bad_run <= '0;
    else if (seed_load || legal)  bad_run <= '0;
    else if (advance && bad_run != 8'hFF) bad_run <= bad_run + 8'd1;
  end

  assert_reset_zero_R1: assert property (@(posedge clk)
    !rst_n |-> (state_q == '0 && phase_oh == PHASES'(1)));

  assert_stay_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (legal && advance) |=> legal);

  assert_feedback_R3: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (state_q[0] == !$past(state_q[STAGES-1]) && state_q[1] == $past(state_q[0])));

  assert_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    legal |-> $onehot(phase_oh));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !seed_load) |=> ($stable(state_q) && $stable(phase_oh)));

  assert_seed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |=> (state_q == $past(seed_value)));

  assert_recover_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bad_run <= 8'(LIMIT));
endmodule

bind johnson_timing_gen jc_timing_checker #(.STAGES(STAGES)) u_jc_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .seed_load  (seed_load),
  .seed_value (seed_value),
  .state_q    (state_q),
  .phase_oh   (phase_oh),
  .legal      (legal_w),
  .advance    (advance_w)
);

// File: tb/test_johnson_timing_gen.sv
`timescale 1ns/1ps
module test_johnson_timing_gen;
  localparam int K = 4;
  localparam int P = 2 * K;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         enable;
  logic         seed_load;
  logic [K-1:0] seed_value;
  logic [K-1:0] state_q;
  logic [P-1:0] phase_oh;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  johnson_timing_gen #(.STAGES(K)) i_johnson_timing_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .seed_load(seed_load),
    .seed_value(seed_value), .state_q(state_q), .phase_oh(phase_oh)
  );

  function automatic logic [K-1:0] ref_state(input int n);
    if (n <= K) return K'((1 << n) - 1);
    return K'(((1 << K) - 1) & ~((1 << (n - K)) - 1));
  endfunction

  function automatic int ref_index(input logic [K-1:0] s);
    for (int n = 0; n < P; n++) if (ref_state(n) == s) return n;
    return -1;
  endfunction

  function automatic logic [P-1:0] ref_phase(input logic [K-1:0] s);
    logic [P-1:0] r;
    r = '0;
    r[0] = !s[0] && !s[K-1];
    r[K] = s[0] && s[K-1];
    for (int j = 1; j < K; j++) begin
      r[j]     = s[j-1] && !s[j];
      r[K + j] = !s[j-1] && s[j];
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [K-1:0] prev;
    int steps;
    int idx;
    rst_n = 1'b0; enable = 1'b0; seed_load = 1'b0; seed_value = '0;
    repeat (3) @(negedge clk);
    check("R1 state", 32'(state_q), 0);
    check("R1 phase", 32'(phase_oh), 1);
    enable = 1'b1;
    @(negedge clk);
    check("R1 held in reset", 32'(state_q), 0);
    rst_n = 1'b1;

    // R2 R3 R4: free run over two full loops
    for (int n = 1; n <= 2 * P; n++) begin
      prev = state_q;
      @(negedge clk);
      check("R2 loop state", 32'(state_q), 32'(ref_state(n % P)));
      check("R3 head inverted", 32'(state_q[0]), 32'(!prev[K-1]));
      check("R3 shift", 32'(state_q[1]), 32'(prev[0]));
      check("R4 phase", 32'(phase_oh), 32'(1) << (n % P));
    end

    // R6: stall
    enable = 1'b0;
    prev = state_q;
    repeat (3) begin
      @(negedge clk);
      check("R6 hold state", 32'(state_q), 32'(prev));
      check("R6 hold phase", 32'(phase_oh), 32'(ref_phase(prev)));
    end

    // R5 R7 R8: every pattern
    for (int p = 0; p < (1 << K); p++) begin
      enable = 1'b0; seed_load = 1'b1; seed_value = K'(p);
      @(negedge clk);
      seed_load = 1'b0;
      check("R7 seed", 32'(state_q), 32'(p));
      check("R5 decode", 32'(phase_oh), 32'(ref_phase(K'(p))));
      @(negedge clk);
      check("R6 seeded hold", 32'(state_q), 32'(p));
      enable = 1'b1;
      steps = 0;
      while (ref_index(state_q) < 0 && steps <= P) begin
        @(negedge clk);
        steps++;
      end
      checks++;
      if (steps > P) begin
        failures++;
        $display("FAIL R8 recover pattern=%0h actual=%0d expected<=%0d", p, steps, P);
      end
      idx = ref_index(state_q);
      @(negedge clk);
      if (idx >= 0) check("R8 then loop", 32'(state_q), 32'(ref_state((idx + 1) % P)));
    end

    // R7: seed wins over enable
    enable = 1'b1; seed_load = 1'b1; seed_value = 4'b1010;
    @(negedge clk);
    seed_load = 1'b0; enable = 1'b0;
    check("R7 priority", 32'(state_q), 32'hA);
    check("R5 decode 1010", 32'(phase_oh), 32'(ref_phase(4'b1010)));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule